// File: doc/BRIEF.md
# Processor Power Mode Controller

This block decides which of three power states the processor is in: RUN (full operation), IDLE (the core and its program-memory clock are gated, while peripherals and the on-chip oscillators keep running) and STOP (the core, every oscillator and therefore every digital peripheral are halted). Software asks for a low-power state by setting one of two select bits in a small power-control register. The state change waits until the instruction that made the write has retired. IDLE ends when any enabled interrupt is pending. STOP ends only through a reset.

Three reset inputs are watched: the external reset pin, comparator 0 and the external convert-start pin. A missing-clock detector adds a fourth source. It counts ticks of a slow, free-running reference. While the system clock is absent it forces a reset once a set number of ticks has passed, so it must be disabled before a long STOP. The source or sources of the latest reset are kept in a status register, so that software can tell what ended STOP. A reset returns the controller to RUN and raises a restart strobe, which tells the core to start again at address 0x0000. The analog shutdown before STOP is left to software.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Writing 1 to bit 0 of register 0 (address 0) sets the idle-select bit. IDLE is entered at the first clock edge after that at which `instr_retire` is high. Until then `cpu_clk_en` stays 1. A retire strobe in the write cycle itself does not count.
- R2: In IDLE, `cpu_clk_en` is 0 while `periph_clk_en` and `osc_en` stay 1.
- R3: In IDLE, any nonzero `irq_pend` returns the controller to RUN at the next edge. `wake` is then 1 for exactly one cycle, and the idle-select bit reads back as 0.
- R4: Any reset event (a bit of `rst_src` high, or the missing-clock detector firing) returns the controller to RUN at the next edge from any state. `cpu_rst` is then high for one cycle per event cycle, both select bits read 0, and the detector enable is set back to 1.
- R5: Writing 1 to bit 1 of register 0 sets the stop-select bit. The next retire enters STOP, in which `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R6: In STOP, `irq_pend` has no effect. The outputs stay at their STOP values until a reset event.
- R7: When the detector is enabled, a tick of `ref_tick` is counted while the system clock is absent (in STOP, or while `sysclk_ok` is 0). The count clears whenever the clock is present. On the MCD_TICKS-th counted tick the detector fires in the following cycle, and that firing is a reset event.
- R8: Bit 0 of register 1 is the detector enable, with reset value 1. When it is 0, no number of ticks causes a reset.
- R9: If both select bits are set when the retire arrives, STOP is entered rather than IDLE.
- R10: Each reset event overwrites the cause field in bits 7:4 of register 1 with the sources active in that cycle: bit 4 for the external pin (`rst_src[0]`), bit 5 for the missing-clock detector, bit 6 for comparator 0 (`rst_src[1]`) and bit 7 for convert-start (`rst_src[2]`). Bits 3:1 read 0.
- R11: After power-on reset, the controller is in RUN with all clock enables at 1, `wake` and `cpu_rst` at 0, register 0 reading 0x00 and register 1 reading 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| instr_retire | input | 1 | Strobe: the current instruction has completed |
| irq_pend | input | IRQ_W | Enabled pending interrupts, one bit each |
| rst_src | input | 3 | Reset sources: [0] external pin, [1] comparator 0, [2] convert-start |
| ref_tick | input | 1 | One-cycle tick of the free-running slow reference |
| sysclk_ok | input | 1 | System oscillator reports a running clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 power control, 1 detector and cause |
| reg_wdata | input | 2 | Write data; register 0 uses both bits, register 1 uses bit 0 |
| reg_rdata | output | 8 | Read data of the register selected by `reg_addr` |
| cpu_clk_en | output | 1 | Clock gate enable for the core and its program memory |
| periph_clk_en | output | 1 | Clock enable for the digital peripherals |
| osc_en | output | 1 | Enable for the oscillators |
| wake | output | 1 | One-cycle pulse when an interrupt ends IDLE |
| cpu_rst | output | 1 | Restart strobe that sends the core to address 0x0000 |

## Verification
The assertions check, on every cycle, that RUN is never left without a retire strobe and that an interrupt in IDLE always produces a single-cycle wake and RUN. They also check that IDLE keeps the peripheral and oscillator enables on, that STOP persists until a reset event, and that every reset event lands in RUN with the restart strobe high. The bench scenarios are needed to show the rest: the count of reference ticks before the detector fires, that disabling the detector keeps STOP alive through a long run of ticks, the STOP-over-IDLE priority, and the exact cause bits read back after each kind of reset.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2
  } pm_state_e;

  localparam int RST_SRC_N = 3;
  localparam int CAUSE_W   = RST_SRC_N + 1;
endpackage

// File: rtl/pmc_mcd.sv
module pmc_mcd #(
  parameter int MCD_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clk_absent,
  input  logic ref_tick,
  output logic fire
);
  localparam int CW = $clog2(MCD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(MCD_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fire  <= 1'b0;
    end else if (!enable || !clk_absent) begin
      cnt_q <= '0;
      fire  <= 1'b0;
    end else if (ref_tick) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        fire  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        fire  <= 1'b0;
      end
    end else begin
      fire <= 1'b0;
    end
  end
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               addr,
  input  logic [1:0]         wr_data,
  input  logic               rst_evt,
  input  logic [CAUSE_W-1:0] new_cause,
  input  logic               clr_idle,
  output logic               idle_sel,
  output logic               stop_sel,
  output logic               mcd_en,
  output logic [7:0]         rd_data
);
  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_sel <= 1'b0;
      stop_sel <= 1'b0;
      mcd_en   <= 1'b1;
      cause_q  <= '0;
    end else if (rst_evt) begin
      idle_sel <= 1'b0;
      stop_sel <= 1'b0;
      mcd_en   <= 1'b1;
      cause_q  <= new_cause;
    end else begin
      if (wr_en && !addr) begin
        idle_sel <= wr_data[0];
        stop_sel <= wr_data[1];
      end
      if (wr_en && addr) begin
        mcd_en <= wr_data[0];
      end
      if (clr_idle) begin
        idle_sel <= 1'b0;
      end
    end
  end

  always_comb begin
    if (addr) rd_data = {cause_q, 3'b000, mcd_en};
    else      rd_data = {6'b000000, stop_sel, idle_sel};
  end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      retire,
  input  logic      idle_sel,
  input  logic      stop_sel,
  input  logic      irq_any,
  input  logic      rst_evt,
  output pm_state_e state,
  output logic      clr_idle,
  output logic      wake,
  output logic      cpu_rst
);
  pm_state_e nxt;

  always_comb begin
    nxt = state;
    if (rst_evt) begin
      nxt = PM_RUN;
    end else begin
      unique case (state)
        PM_RUN: begin
          if (retire && stop_sel)      nxt = PM_STOP;
          else if (retire && idle_sel) nxt = PM_IDLE;
        end
        PM_IDLE: if (irq_any) nxt = PM_RUN;
        PM_STOP: nxt = PM_STOP;
        default: nxt = PM_RUN;
      endcase
    end
  end

  assign clr_idle = (state == PM_IDLE) && irq_any && !rst_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PM_RUN;
      wake    <= 1'b0;
      cpu_rst <= 1'b0;
    end else begin
      state   <= nxt;
      wake    <= clr_idle;
      cpu_rst <= rst_evt;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int IRQ_W     = 8,
  parameter int MCD_TICKS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_retire,
  input  logic [IRQ_W-1:0]     irq_pend,
  input  logic [RST_SRC_N-1:0] rst_src,
  input  logic                 ref_tick,
  input  logic                 sysclk_ok,
  input  logic                 reg_wr,
  input  logic                 reg_addr,
  input  logic [1:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output logic                 cpu_clk_en,
  output logic                 periph_clk_en,
  output logic                 osc_en,
  output logic                 wake,
  output logic                 cpu_rst
);
  pm_state_e          state;
  logic               idle_sel, stop_sel, mcd_en, mcd_fire;
  logic               rst_evt, clr_idle, clk_absent;
  logic [CAUSE_W-1:0] new_cause;

  assign rst_evt    = (|rst_src) | mcd_fire;
  assign new_cause  = {rst_src[2], rst_src[1], mcd_fire, rst_src[0]};
  assign clk_absent = !osc_en || !sysclk_ok;

  assign cpu_clk_en    = (state == PM_RUN);
  assign periph_clk_en = (state != PM_STOP);
  assign osc_en        = (state != PM_STOP);

  pmc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wr_data(reg_wdata), .rst_evt(rst_evt), .new_cause(new_cause),
    .clr_idle(clr_idle), .idle_sel(idle_sel), .stop_sel(stop_sel),
    .mcd_en(mcd_en), .rd_data(reg_rdata)
  );

  pmc_mcd #(.MCD_TICKS(MCD_TICKS)) u_mcd (
    .clk(clk), .rst_n(rst_n), .enable(mcd_en), .clk_absent(clk_absent),
    .ref_tick(ref_tick), .fire(mcd_fire)
  );

  pmc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .retire(instr_retire), .idle_sel(idle_sel),
    .stop_sel(stop_sel), .irq_any(|irq_pend), .rst_evt(rst_evt),
    .state(state), .clr_idle(clr_idle), .wake(wake), .cpu_rst(cpu_rst)
  );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_retire,
  input logic [IRQ_W-1:0] irq_pend,
  input logic             rst_evt,
  input logic             cpu_clk_en,
  input logic             periph_clk_en,
  input logic             osc_en,
  input logic             wake,
  input logic             cpu_rst
);
  AST_RUN_HOLDS_UNTIL_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !instr_retire) |=> cpu_clk_en); // R1

  AST_IDLE_KEEPS_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && periph_clk_en && !(|irq_pend) && !rst_evt)
      |=> (!cpu_clk_en && periph_clk_en && osc_en)); // R2

  AST_IDLE_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && periph_clk_en && (|irq_pend) && !rst_evt)
      |=> (cpu_clk_en && wake)); // R3

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake); // R3

  AST_RESET_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (cpu_clk_en && cpu_rst && !wake)); // R4

  AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !rst_evt) |=> (!osc_en && !periph_clk_en && !cpu_clk_en)); // R6
endmodule

bind pwr_mode_ctrl pmc_checker #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_retire(instr_retire), .irq_pend(irq_pend),
  .rst_evt(rst_evt), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
  .osc_en(osc_en), .wake(wake), .cpu_rst(cpu_rst)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int IRQ_W = 8;
  localparam int TICKS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_retire = 1'b0;
  logic [IRQ_W-1:0] irq_pend = '0;
  logic [2:0] rst_src = '0;
  logic ref_tick = 1'b0;
  logic sysclk_ok = 1'b1;
  logic reg_wr = 1'b0;
  logic reg_addr = 1'b0;
  logic [1:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic cpu_clk_en, periph_clk_en, osc_en, wake, cpu_rst;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R11";

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.IRQ_W(IRQ_W), .MCD_TICKS(TICKS)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .instr_retire(instr_retire), .irq_pend(irq_pend),
    .rst_src(rst_src), .ref_tick(ref_tick), .sysclk_ok(sysclk_ok),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .osc_en(osc_en), .wake(wake), .cpu_rst(cpu_rst)
  );

  // Behavioural reference: mode 0 run, 1 idle, 2 stop
  int m_mode, m_cnt;
  bit m_idle, m_stop, m_mcden, m_fire, m_wake, m_rst;
  bit [3:0] m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_idle = 0; m_stop = 0; m_mcden = 1;
      m_fire = 0; m_wake = 0; m_rst = 0; m_cause = 0;
    end else begin
      bit evt, absent, old_fire, old_idle, old_stop;
      evt = (rst_src != 0) || m_fire;
      absent = (m_mode == 2) || !sysclk_ok;
      old_fire = m_fire; old_idle = m_idle; old_stop = m_stop;
      m_fire = 0;
      if (!m_mcden || !absent) m_cnt = 0;
      else if (ref_tick) begin
        if (m_cnt == TICKS - 1) begin m_cnt = 0; m_fire = 1; end
        else m_cnt = m_cnt + 1;
      end
      m_wake = 0;
      m_rst = evt;
      if (evt) begin
        m_mode = 0; m_idle = 0; m_stop = 0; m_mcden = 1;
        m_cause = {rst_src[2], rst_src[1], old_fire, rst_src[0]};
      end else begin
        if (reg_wr && !reg_addr) begin m_idle = reg_wdata[0]; m_stop = reg_wdata[1]; end
        if (reg_wr && reg_addr) m_mcden = reg_wdata[0];
        if (m_mode == 0) begin
          if (instr_retire && old_stop) m_mode = 2;
          else if (instr_retire && old_idle) m_mode = 1;
        end else if (m_mode == 1 && irq_pend != 0) begin
          m_mode = 0; m_idle = 0; m_wake = 1;
        end
      end
    end
  end

  function automatic logic [7:0] model_rdata();
    if (reg_addr) return {m_cause, 3'b000, m_mcden};
    return {6'b0, m_stop, m_idle};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, 1 ns after each edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(cur_req, {27'b0, cpu_clk_en, periph_clk_en, osc_en, wake, cpu_rst},
            {27'b0, m_mode == 0, m_mode != 2, m_mode != 2, m_wake, m_rst});
      check(cur_req, {24'b0, reg_rdata}, {24'b0, model_rdata()});
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit a, bit [1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic retire();
    instr_retire = 1; step(); instr_retire = 0;
  endtask

  task automatic rd(string req, bit a, logic [7:0] exp);
    reg_addr = a; #0.5;
    check(req, {24'b0, reg_rdata}, {24'b0, exp});
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      ref_tick = 1; step(); ref_tick = 0; step(3);
    end
  endtask

  task automatic pulse_rst(bit [2:0] s);
    rst_src = s; step(); rst_src = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R11 reset state
    check("R11", {28'b0, cpu_clk_en, periph_clk_en, osc_en, wake}, 32'he);
    check("R11", {31'b0, cpu_rst}, 0);
    rd("R11", 0, 8'h00);
    rd("R11", 1, 8'h01);

    // R1 idle entry waits for retire; retire in write cycle ignored
    cur_req = "R1";
    instr_retire = 1; wr(0, 2'b01); instr_retire = 0;
    check("R1", {31'b0, cpu_clk_en}, 1);
    step(3);
    check("R1", {31'b0, cpu_clk_en}, 1);
    rd("R1", 0, 8'h01);
    retire();
    check("R1", {31'b0, cpu_clk_en}, 0);
    cur_req = "R2";
    step(4);
    check("R2", {30'b0, periph_clk_en, osc_en}, 3);

    // R3 interrupt wakes from idle
    cur_req = "R3";
    irq_pend = 8'h04; step(); irq_pend = 0;
    check("R3", {30'b0, cpu_clk_en, wake}, 3);
    rd("R3", 0, 8'h00);
    step();
    check("R3", {31'b0, wake}, 0);

    // R4 reset from idle via comparator, R10 cause
    cur_req = "R4";
    wr(0, 2'b01); retire();
    check("R4", {31'b0, cpu_clk_en}, 0);
    pulse_rst(3'b010);
    check("R4", {30'b0, cpu_clk_en, cpu_rst}, 3);
    rd("R10", 1, 8'h41);
    rd("R4", 0, 8'h00);
    step();

    // R5 stop, R6 irq ignored, R7 detector ends stop
    cur_req = "R5";
    wr(0, 2'b10); retire();
    check("R5", {29'b0, cpu_clk_en, periph_clk_en, osc_en}, 0);
    cur_req = "R6";
    irq_pend = 8'hff; step(2); irq_pend = 0;
    check("R6", {29'b0, cpu_clk_en, periph_clk_en, osc_en, wake}, 0);
    cur_req = "R7";
    ticks(TICKS - 1);
    check("R7", {31'b0, osc_en}, 0);
    ref_tick = 1; step(); ref_tick = 0;
    check("R7", {31'b0, osc_en}, 0);
    step();
    check("R7", {30'b0, cpu_clk_en, cpu_rst}, 3);
    rd("R10", 1, 8'h21);
    step(2);

    // R8 detector disabled keeps stop through many ticks
    cur_req = "R8";
    wr(1, 2'b00);
    rd("R8", 1, 8'h20);
    wr(0, 2'b10); retire();
    ticks(TICKS + 5);
    check("R8", {29'b0, cpu_clk_en, periph_clk_en, osc_en}, 0);
    cur_req = "R4";
    pulse_rst(3'b001);
    check("R4", {30'b0, cpu_clk_en, cpu_rst}, 3);
    rd("R10", 1, 8'h11);
    step(2);

    // R9 both bits: stop wins
    cur_req = "R9";
    wr(0, 2'b11);
    rd("R9", 0, 8'h03);
    retire();
    check("R9", {29'b0, cpu_clk_en, periph_clk_en, osc_en}, 0);
    step(3);
    cur_req = "R10";
    pulse_rst(3'b100);
    rd("R10", 1, 8'h81);
    step(2);

    // R7 detector in run mode with failed clock
    cur_req = "R7";
    sysclk_ok = 0;
    ticks(TICKS - 1);
    check("R7", {31'b0, cpu_rst}, 0);
    ref_tick = 1; step(); ref_tick = 0;
    step();
    sysclk_ok = 1;
    check("R7", {31'b0, cpu_rst}, 1);
    rd("R10", 1, 8'h21);
    step(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule